// File: doc/BRIEF.md
# Integer ALU With Condition Codes

This block is the arithmetic and logic unit of a small processor datapath. Each cycle it takes two W-bit operands, a 4-bit operation selector and a flag-update enable, and on the next clock edge presents the registered result. It supports addition, subtraction, bitwise AND and bitwise XOR. Subtraction takes the first operand away from the second, which matches the "destination minus source" order of two-operand instructions.

Three condition flags are held in registers: zero, negative (the result's top bit) and signed overflow. They load only on an edge where the enable is high and the operation code is valid. This lets the same adder compute addresses or stack-pointer steps while leaving the flags of an earlier compare intact. A combinational condition evaluator reads the stored flags and a 4-bit condition selector. It tells a conditional jump or conditional move whether to act.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation code 0 (add) puts opnd_a + opnd_b, modulo 2^W, on `result` one clock edge after the operands are applied.
- R2: Operation code 1 (subtract) yields opnd_b - opnd_a, modulo 2^W, one edge later.
- R3: Operation code 2 yields opnd_a AND opnd_b and code 3 yields opnd_a XOR opnd_b, one edge later.
- R4: On an edge with set_cc high and a valid code, flag_z becomes 1 exactly when the new result is zero, and flag_s becomes the new result's top bit.
- R5: On such an edge, flag_o is set for add when both operands share a sign that the sum lacks. It is set for subtract when the operand signs differ and the difference's sign differs from opnd_b's sign.
- R6: An AND or XOR with set_cc high clears flag_o.
- R7: With set_cc low, all three flags keep their values while `result` still updates.
- R8: Operation codes 4 to 15 give a zero result and leave all flags unchanged, even with set_cc high.
- R9: cond_true follows cond_sel from the stored flags: 0 always 1; 1 (SF^OF)|ZF; 2 SF^OF; 3 ZF; 4 !ZF; 5 !(SF^OF); 6 !(SF^OF)&!ZF.
- R10: cond_sel values 7 to 15 give cond_true = 0.
- R11: Synchronous active-high reset sets result to 0, flag_z to 1, and flag_s and flag_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | W | Source operand |
| opnd_b | input | W | Destination operand |
| func | input | 4 | Operation code |
| set_cc | input | 1 | Allow the flags to load on this edge |
| cond_sel | input | 4 | Condition selector for jump/move decisions |
| result | output | W | Registered result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Evaluated condition for cond_sel |

## Verification
The hardest states to reach are the flag combinations where SF and OF disagree. These occur only on signed wrap, so the vector table includes the boundary sums and differences around the most positive and most negative values. After each vector the bench sweeps every condition selector. A logic operation then follows an overflowing one, to show OF being cleared. Updates with the enable low and with invalid codes follow a flag-changing operation, so that any unwanted load shows up on the flag outputs.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int FN_W   = 4;
  localparam int COND_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } flags_t;
endpackage

// File: rtl/alu_cc_core.sv
module alu_cc_core
  import alu_cc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    res,
  output logic            ovf,
  output logic            fn_ok
);
  localparam int MSB = W - 1;

  logic [W-1:0] sum, diff;
  assign sum  = a + b;
  assign diff = b - a;

  always_comb begin
    res   = '0;
    ovf   = 1'b0;
    fn_ok = 1'b1;
    case (fn)
      FN_ADD: begin
        res = sum;
        ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      FN_SUB: begin
        res = diff;
        ovf = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
      end
      FN_AND: res = a & b;
      FN_XOR: res = a ^ b;
      default: fn_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_flags.sv
module alu_cc_flags
  import alu_cc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  flags_t nxt,
  output flags_t cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '{z: 1'b1, s: 1'b0, o: 1'b0};
    else if (load) cur <= nxt;
  end
endmodule

// File: rtl/alu_cc_cond.sv
module alu_cc_cond
  import alu_cc_pkg::*;
(
  input  logic [COND_W-1:0] sel,
  input  flags_t            f,
  output logic              take
);
  logic lt;
  assign lt = f.s ^ f.o;

  always_comb begin
    case (sel)
      CC_ALWAYS: take = 1'b1;
      CC_LE:     take = lt | f.z;
      CC_LT:     take = lt;
      CC_EQ:     take = f.z;
      CC_NE:     take = ~f.z;
      CC_GE:     take = ~lt;
      CC_GT:     take = ~lt & ~f.z;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic [FN_W-1:0]   func,
  input  logic              set_cc,
  input  logic [COND_W-1:0] cond_sel,
  output logic [W-1:0]      result,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              cond_true
);
  logic [W-1:0] res_c;
  logic         ovf_c, fn_ok;
  flags_t       nxt_f, cur_f;

  alu_cc_core #(.W(W)) u_core (
    .a(opnd_a), .b(opnd_b), .fn(func),
    .res(res_c), .ovf(ovf_c), .fn_ok(fn_ok)
  );

  assign nxt_f = '{z: (res_c == '0), s: res_c[W-1], o: ovf_c};

  alu_cc_flags u_flags (
    .clk(clk), .rst(rst), .load(set_cc & fn_ok), .nxt(nxt_f), .cur(cur_f)
  );

  alu_cc_cond u_cond (.sel(cond_sel), .f(cur_f), .take(cond_true));

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= res_c;
  end

  assign flag_z = cur_f.z;
  assign flag_s = cur_f.s;
  assign flag_o = cur_f.o;
endmodule

// File: rtl/alu_cc_unit_chk.sv
module alu_cc_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   func,
  input logic         set_cc,
  input logic [3:0]   cond_sel,
  input logic [W-1:0] result,
  input logic         flag_z,
  input logic         flag_s,
  input logic         flag_o,
  input logic         cond_true
);
  a_r11_reset_flags: assert property (@(posedge clk)
    rst |=> (flag_z && !flag_s && !flag_o && result == '0));

  a_r7_hold_flags: assert property (@(posedge clk) disable iff (rst)
    !set_cc |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_o)));

  a_r8_bad_func: assert property (@(posedge clk) disable iff (rst)
    (func > 4'd3) |=> (result == '0 && $stable(flag_z) && $stable(flag_s) && $stable(flag_o)));

  a_r4_zero_sign: assert property (@(posedge clk) disable iff (rst)
    (set_cc && func <= 4'd3) |=> (flag_z == (result == '0) && flag_s == result[W-1]));

  a_r6_logic_clears_of: assert property (@(posedge clk) disable iff (rst)
    (set_cc && (func == 4'd2 || func == 4'd3)) |=> !flag_o);

  always_comb begin
    if (!rst) begin
      if (cond_sel == 4'd0) a_r9_always: assert (cond_true);
      if (cond_sel == 4'd3) a_r9_equal: assert (cond_true == flag_z);
      if (cond_sel == 4'd2) a_r9_less: assert (cond_true == (flag_s ^ flag_o));
      if (cond_sel > 4'd6)  a_r10_undef_cond: assert (!cond_true);
    end
  end
endmodule

bind alu_cc_unit alu_cc_unit_chk #(.W(W)) u_chk (.*);

// File: tb/alu_cc_unit_test.sv
`timescale 1ns/100ps
module alu_cc_unit_test;
  localparam int W = 64;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [3:0]   f;
    logic [W-1:0] r;
    logic         z;
    logic         s;
    logic         o;
  } vec_t;

  localparam logic [W-1:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [W-1:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [W-1:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VECS [0:9] = '{
    '{64'd5, 64'd7, 4'd0, 64'd12, 1'b0, 1'b0, 1'b0},
    '{MAXP, 64'd1, 4'd0, MINN, 1'b0, 1'b1, 1'b1},
    '{MINN, 64'd0, 4'd3, MINN, 1'b0, 1'b1, 1'b0},
    '{MINN, MINN, 4'd0, 64'd0, 1'b1, 1'b0, 1'b1},
    '{64'd3, 64'd3, 4'd1, 64'd0, 1'b1, 1'b0, 1'b0},
    '{64'd5, 64'd2, 4'd1, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 1'b1, 1'b0},
    '{64'd1, MINN, 4'd1, MAXP, 1'b0, 1'b0, 1'b1},
    '{64'hFF00_FF00_FF00_FF00, 64'hF0F0_F0F0_F0F0_F0F0, 4'd2,
      64'hF000_F000_F000_F000, 1'b0, 1'b1, 1'b0},
    '{ONES, ONES, 4'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, 1'b0},
    '{64'd123, 64'd123, 4'd3, 64'd0, 1'b1, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] opnd_a, opnd_b;
  logic [3:0]   func, cond_sel;
  logic         set_cc;
  logic [W-1:0] result;
  logic         flag_z, flag_s, flag_o, cond_true;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  alu_cc_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .func(func),
    .set_cc(set_cc), .cond_sel(cond_sel), .result(result),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .cond_true(cond_true)
  );

  function automatic logic cond_ref(int c, logic z, logic s, logic o);
    case (c)
      0: return 1'b1;
      1: return (s ^ o) | z;
      2: return s ^ o;
      3: return z;
      4: return !z;
      5: return !(s ^ o);
      6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req, logic z, logic s, logic o);
    check({req, " zf"}, W'(flag_z), W'(z));
    check({req, " sf"}, W'(flag_s), W'(s));
    check({req, " of"}, W'(flag_o), W'(o));
  endtask

  // R9 R10: sweep all selectors against the stored flags; set_cc is low so flags hold
  task automatic sweep_cond(logic z, logic s, logic o);
    set_cc = 1'b0;
    for (int c = 0; c < 16; c++) begin
      cond_sel = 4'(c);
      #0.5;
      check(c < 7 ? "R9 cond" : "R10 undefined cond", W'(cond_true), W'(cond_ref(c, z, s, o)));
    end
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] f, logic en);
    @(negedge clk);
    opnd_a = a; opnd_b = b; func = f; set_cc = en;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; opnd_a = '0; opnd_b = '0; func = 4'd0; set_cc = 1'b0; cond_sel = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset result", result, '0);
    check_flags("R11 reset", 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Table walk: R1 R2 R3 results, R4 R5 R6 flags
    for (int i = 0; i < 10; i++) begin
      apply(VECS[i].a, VECS[i].b, VECS[i].f, 1'b1);
      check($sformatf("R1/R2/R3 result row %0d", i), result, VECS[i].r);
      check_flags($sformatf("R4/R5/R6 row %0d", i), VECS[i].z, VECS[i].s, VECS[i].o);
      sweep_cond(VECS[i].z, VECS[i].s, VECS[i].o);
    end

    // Set Z=0,S=1,O=1 then exercise R7 hold
    apply(MAXP, 64'd1, 4'd0, 1'b1);
    check_flags("R5 add overflow", 1'b0, 1'b1, 1'b1);
    apply(64'd0, 64'd0, 4'd0, 1'b0);
    check("R7 result still updates", result, '0);
    check_flags("R7 flags held", 1'b0, 1'b1, 1'b1);
    apply(64'd4, 64'd4, 4'd3, 1'b0);
    check_flags("R7 flags held after xor", 1'b0, 1'b1, 1'b1);
    sweep_cond(1'b0, 1'b1, 1'b1);

    // R8 invalid codes with set_cc high
    for (int f = 4; f < 16; f += 5) begin
      apply(64'd9, 64'd9, 4'(f), 1'b1);
      check($sformatf("R8 zero result code %0d", f), result, '0);
      check_flags("R8 flags unchanged", 1'b0, 1'b1, 1'b1);
    end

    // R6 logic after overflow clears OF
    apply(ONES, MINN, 4'd2, 1'b1);
    check("R3 and result", result, MINN);
    check_flags("R6 of cleared", 1'b0, 1'b1, 1'b0);

    // R5 subtract no overflow at opposite-sign boundary
    apply(MAXP, ONES, 4'd1, 1'b1);
    check("R2 sub boundary", result, MINN);
    check_flags("R5 sub -1-max", 1'b0, 1'b1, 1'b0);

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R11 mid-run reset result", result, '0);
    check_flags("R11 mid-run reset", 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule